// File: doc/BRIEF.md
# Unique Line Access History Log

This block records, in age order, the distinct cache lines that a second-level cache prefetcher has recently seen. Every access presented on the input carries a byte address and a flag that says whether it missed. The block drops the byte offset within a 64-byte line. It then compares the resulting line address against every valid logged entry in the same cycle. The line is logged only when none of them holds it. Because repeated touches of a line already in the log are discarded, a hot line cannot push older, more informative history out of the window.

The log keeps 128 entries, each a 26-bit line address plus two info bits that record whether the logging access was a hit or a miss. When a new distinct line arrives and the log is full, the oldest entry is dropped. A pattern detector reads the log through an age-indexed port, where age 0 is the newest entry. A one-cycle pulse on each append tells the detector when to start a new analysis.

Top module: `line_hist_log`

## Requirements
- R1: After reset, every age reads back as invalid and `new_entry` is low.
- R2: The line address is `acc_addr[31:6]`. Bits 5:0 of the address affect neither matching nor the stored value.
- R3: A logged entry's info bits are 2'b10 when `acc_miss` was 1 and 2'b01 when it was 0.
- R4: When `acc_valid` is high and the line address matches no valid entry, the line appears at age 0 after the next rising clock edge. Every previously logged entry moves one age older.
- R5: When `acc_valid` is high and the line address equals a valid entry, the log is unchanged after the edge, including that entry's info bits.
- R6: When the log holds 128 valid entries and a new distinct line is logged, the entry that was at age 127 is discarded.
- R7: `new_entry` is high for exactly the one cycle that follows a clock edge at which a line was logged, and low in every other cycle.
- R8: `rd_valid`, `rd_line` and `rd_info` follow `rd_age` in the same cycle. `rd_valid` is high exactly for ages below the number of logged entries, and the valid ages form a contiguous run from age 0.
- R9: While `acc_valid` is low, the address and miss inputs have no effect on the log.
- R10: A line that was discarded no longer matches, so a later access to it is logged again as new.
- R11: Invalid slots never match, so the first access after reset is logged even when its line address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_miss | input | 1 | 1 when the access missed the cache |
| rd_age | input | 7 | Age of the entry to read, 0 is newest |
| rd_valid | output | 1 | The entry at `rd_age` is logged |
| rd_line | output | 26 | Line address of the entry at `rd_age` |
| rd_info | output | 2 | Hit/miss info bits of the entry at `rd_age` |
| new_entry | output | 1 | One-cycle pulse after a line was logged |

## Verification
A behavioural queue model runs alongside the block, and after every clock the bench walks all 128 ages and compares them with the model. Accesses to zero-valued lines just after reset show whether invalid slots can match. Repeats of a line with a different byte offset and the opposite hit flag show whether the offset is truly dropped and whether a duplicate alters the stored entry. A run of more than 128 distinct lines, followed by accesses both to lines just pushed out and to lines still present, separates age-based discard from a wrong eviction order or stale matching. Back-to-back repeats of one new line, and cycles where the address changes while the access strobe is low, check that the append pulse and the strobe qualification are right.

// File: rtl/line_hist_log.sv
module line_hist_log #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int DEPTH      = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic                       acc_miss,
  input  logic [$clog2(DEPTH)-1:0]   rd_age,
  output logic                       rd_valid,
  output logic [ADDR_W-LINE_SHIFT-1:0] rd_line,
  output logic [1:0]                 rd_info,
  output logic                       new_entry
);
  localparam int LINE_W = ADDR_W - LINE_SHIFT;

  logic [LINE_W-1:0] line_q [DEPTH];
  logic [1:0]        info_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  hit_vec;
  logic [LINE_W-1:0] acc_line;
  logic [1:0]        acc_info;
  logic              append;
  logic              unused_offset;

  assign acc_line      = acc_addr[ADDR_W-1:LINE_SHIFT];
  assign acc_info      = acc_miss ? 2'b10 : 2'b01;
  assign unused_offset = ^acc_addr[LINE_SHIFT-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (line_q[g] == acc_line);
  end

  assign append = acc_valid && !(|hit_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      new_entry <= 1'b0;
    end else begin
      new_entry <= append;
      if (append) vld_q <= {vld_q[DEPTH-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (append) begin
      line_q[0] <= acc_line;
      info_q[0] <= acc_info;
      for (int i = 1; i < DEPTH; i++) begin
        line_q[i] <= line_q[i-1];
        info_q[i] <= info_q[i-1];
      end
    end
  end

  assign rd_valid = vld_q[rd_age];
  assign rd_line  = line_q[rd_age];
  assign rd_info  = info_q[rd_age];
endmodule

// File: rtl/line_hist_log_chk.sv
module line_hist_log_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int DEPTH      = 128
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_valid,
  input logic [ADDR_W-1:0]             acc_addr,
  input logic                          acc_miss,
  input logic                          new_entry,
  input logic [DEPTH-1:0]              vld,
  input logic [ADDR_W-LINE_SHIFT-1:0]  head_line,
  input logic [1:0]                    head_info
);
  logic [DEPTH-1:0] vld_inc;
  assign vld_inc = vld + 1'b1;

  // R7
  new_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_entry |-> $past(acc_valid));

  // R4
  head_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_entry |-> (head_line == $past(acc_addr[ADDR_W-1:LINE_SHIFT])));

  // R3
  head_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_entry |-> (head_info == ($past(acc_miss) ? 2'b10 : 2'b01)));

  // R4
  head_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_entry |-> vld[0]);

  // R8
  valid_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_inc & vld) == '0);

  // R5
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !new_entry |-> ($stable(vld) && $stable(head_line) && $stable(head_info)));
endmodule

bind line_hist_log line_hist_log_chk #(
  .ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_miss(acc_miss), .new_entry(new_entry), .vld(vld_q),
  .head_line(line_q[0]), .head_info(info_q[0])
);

// File: tb/line_hist_log_bench.sv
`timescale 1ns/1ps
module line_hist_log_bench;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_miss = 1'b0;
  logic [6:0]  rd_age = '0;
  logic        rd_valid;
  logic [25:0] rd_line;
  logic [1:0]  rd_info;
  logic        new_entry;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [27:0] model [$];
  bit exp_new = 1'b0;

  always #2 clk = ~clk;

  line_hist_log u_line_hist_log (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_miss(acc_miss), .rd_age(rd_age), .rd_valid(rd_valid),
    .rd_line(rd_line), .rd_info(rd_info), .new_entry(new_entry)
  );

  task automatic check_state(input string tag);
    bit ok = 1'b1;
    total++;
    if (new_entry !== exp_new) begin
      $display("FAIL %s new_entry: actual=%0b expected=%0b", tag, new_entry, exp_new);
      ok = 1'b0;
    end
    for (int a = 0; a < DEPTH; a++) begin
      logic ev;
      logic [27:0] ee;
      rd_age = a[6:0];
      #0.01;
      ev = (a < model.size());
      ee = ev ? model[a] : 28'h0;
      if (ok && rd_valid !== ev) begin
        $display("FAIL %s age %0d valid: actual=%0b expected=%0b", tag, a, rd_valid, ev);
        ok = 1'b0;
      end else if (ok && ev && {rd_line, rd_info} !== ee) begin
        $display("FAIL %s age %0d entry: actual=%h/%b expected=%h/%b",
                 tag, a, rd_line, rd_info, ee[27:2], ee[1:0]);
        ok = 1'b0;
      end
    end
    if (!ok) bad++;
  endtask

  task automatic step(input bit v, input logic [31:0] addr, input bit miss, input string tag);
    bit found = 1'b0;
    acc_valid = v;
    acc_addr  = addr;
    acc_miss  = miss;
    @(posedge clk);
    #1;
    if (v) begin
      foreach (model[k]) if (model[k][27:2] == addr[31:6]) found = 1'b1;
      if (!found) begin
        model.push_front({addr[31:6], miss ? 2'b10 : 2'b01});
        if (model.size() > DEPTH) void'(model.pop_back());
      end
    end
    exp_new = v && !found;
    check_state(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    check_state("R1 reset");
    #3;
    rst_n = 1'b1;
    step(1'b0, 32'h0, 1'b0, "R1 idle after reset");
    step(1'b1, 32'h0000_0000, 1'b0, "R11 zero line first");
    step(1'b1, 32'h0000_003F, 1'b1, "R2 same line other offset, R5 info kept");
    step(1'b1, 32'h0000_1040, 1'b1, "R3 miss info, R4 append");
    step(1'b0, 32'h0000_2000, 1'b1, "R9 strobe low");
    step(1'b1, 32'h0000_2000, 1'b0, "R4 new line");
    step(1'b1, 32'h0000_2010, 1'b1, "R7 repeat no pulse");
    step(1'b0, 32'h0000_2010, 1'b0, "R7 pulse gone");
    step(1'b1, 32'h0000_1040, 1'b0, "R5 older dup");
    for (int i = 0; i < 130; i++)
      step(1'b1, 32'h0010_0000 + i * 32'h1C0 + (i % 64), i[0], "R6 fill and evict");
    step(1'b1, 32'h0000_0000, 1'b1, "R10 evicted zero line back");
    step(1'b1, 32'h0000_1040, 1'b0, "R10 evicted line back");
    step(1'b1, 32'h0010_0000 + 100 * 32'h1C0, 1'b1, "R5 dup deep in full log");
    step(1'b1, 32'hFFFF_FFC0, 1'b1, "R2 top line");
    step(1'b1, 32'hFFFF_FFFF, 1'b0, "R2 top line dup");
    step(1'b0, 32'h1234_5678, 1'b1, "R9 strobe low full");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule